// File: doc/BRIEF.md
# Interleaved Stride DMA Address Generator

This block produces the sequence of quadword memory addresses that one DMA channel walks through. It is loaded with a start address, a total quadword count and a mode. In linear mode it walks one contiguous run. In strided mode it walks a run of consecutive quadwords, jumps over a programmed number of quadwords, and repeats until the total is used up. Each address goes out through a valid/ready handshake. A one-cycle completion pulse follows the last accepted address. The data itself is moved elsewhere; this block only sequences addresses.

All inputs are captured on the cycle a start is accepted, so a transfer is not affected by later changes. The controller is a four-state machine. In IDLE it waits for a start. In EMIT it presents addresses. In DONE it raises the completion pulse. In FAULT it raises the configuration-error pulse.

Its transitions are:
- IDLE to FAULT on a start with a bad configuration.
- IDLE to DONE on a start with a zero total.
- IDLE to EMIT on any other start.
- EMIT to DONE when the final address is accepted.
- DONE to IDLE and FAULT to IDLE unconditionally.

Top module: `ilv_addr_gen`

## Requirements
- R1: After reset, addr_valid_o, done_o and cfg_err_o are all low.
- R2: A start in linear mode (mode 0) with total N > 0 presents N addresses, one per handshake: base, base+16, base+32, and so on. The first address is valid in the cycle after the start edge.
- R3: In strided mode (mode 2), with run count T and skip count S, address i equals base + 16*(i + floor(i/T)*S). The transfer may end in the middle of a run.
- R4: After the final handshake, done_o is high for exactly one cycle and addr_valid_o is low in that cycle.
- R5: A valid start with total 0 raises done_o for one cycle, in the cycle after the start edge, and presents no address.
- R6: A start with mode 1 or mode 3, or with mode 2 and run count 0, raises cfg_err_o for one cycle, in the cycle after the start edge. No address and no done follow. This check takes precedence over a zero total.
- R7: While addr_valid_o is high and addr_ready_i is low, addr_valid_o stays high and addr_o stays unchanged in the next cycle.
- R8: Bits 3:0 of the start address are ignored, and every address presented has bits 3:0 equal to zero.
- R9: A start is acted on only in IDLE. While a transfer is running, a start or changes to mode, address, counts or skip have no effect on the addresses presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (acted on in IDLE) |
| mode_i | input | 2 | 0 linear, 2 strided, 1 and 3 rejected |
| base_addr_i | input | AW | Start byte address |
| total_qw_i | input | TW | Total quadwords to emit |
| run_qw_i | input | SW | Quadwords per run in strided mode |
| skip_qw_i | input | SW | Quadwords jumped after each run |
| addr_o | output | AW | Current quadword address |
| addr_valid_o | output | 1 | addr_o is offered |
| addr_ready_i | input | 1 | Consumer accepts addr_o |
| done_o | output | 1 | One-cycle pulse after the last address |
| cfg_err_o | output | 1 | One-cycle pulse on a rejected start |

## Verification
A start is sampled at clock edge k. The first address, the zero-total done pulse and the error pulse all appear in the cycle after edge k. Each following address appears in the cycle after the edge that takes the previous handshake. The done pulse appears in the cycle after the edge that takes the final handshake. The bench drives inputs and samples outputs on the falling edge, so every check reads the state left by exactly one preceding rising edge. The bench compares the address against the stride formula in every cycle, including stalled ones. It then checks each pulse on its own cycle and confirms the pulse is gone one cycle later.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int QW_SHIFT = 4;
    localparam int QW_BYTES = 1 << QW_SHIFT;

    localparam logic [1:0] MODE_LINEAR  = 2'd0;
    localparam logic [1:0] MODE_LINKED  = 2'd1;
    localparam logic [1:0] MODE_STRIDED = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EMIT  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } ilv_state_e;
endpackage

// File: rtl/ilv_cfg_check.sv
module ilv_cfg_check
    import ilv_pkg::*;
#(
    parameter int TW = 16,
    parameter int SW = 8
) (
    input  logic [1:0]    mode_i,
    input  logic [TW-1:0] total_qw_i,
    input  logic [SW-1:0] run_qw_i,
    output logic          cfg_bad_o,
    output logic          total_zero_o,
    output logic          strided_o
);
    logic mode_known;

    always_comb begin
        mode_known   = (mode_i == MODE_LINEAR) || (mode_i == MODE_STRIDED);
        strided_o    = (mode_i == MODE_STRIDED);
        cfg_bad_o    = !mode_known || (strided_o && (run_qw_i == '0));
        total_zero_o = (total_qw_i == '0);
    end
endmodule

// File: rtl/ilv_stride_cnt.sv
module ilv_stride_cnt
    import ilv_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 16,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          beat_i,
    input  logic          strided_i,
    input  logic [AW-1:0] base_i,
    input  logic [TW-1:0] total_i,
    input  logic [SW-1:0] run_i,
    input  logic [SW-1:0] skip_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(QW_BYTES - 1);
    localparam logic [AW-1:0] STEP       = AW'(QW_BYTES);

    logic [AW-1:0] addr_q;
    logic [TW-1:0] remain_q;
    logic [SW-1:0] run_left_q;
    logic [SW-1:0] run_cfg_q;
    logic [SW-1:0] skip_cfg_q;
    logic          strided_q;
    logic [AW-1:0] jump;
    logic          run_end;

    always_comb begin
        jump    = (AW'(skip_cfg_q) + AW'(1)) << QW_SHIFT;
        run_end = strided_q && (run_left_q == SW'(1));
        addr_o  = addr_q;
        last_o  = (remain_q == TW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            remain_q   <= '0;
            run_left_q <= '0;
            run_cfg_q  <= '0;
            skip_cfg_q <= '0;
            strided_q  <= 1'b0;
        end else if (load_i) begin
            addr_q     <= base_i & ALIGN_MASK;
            remain_q   <= total_i;
            run_left_q <= run_i;
            run_cfg_q  <= run_i;
            skip_cfg_q <= skip_i;
            strided_q  <= strided_i;
        end else if (beat_i) begin
            remain_q <= remain_q - TW'(1);
            if (run_end) begin
                addr_q     <= addr_q + jump;
                run_left_q <= run_cfg_q;
            end else begin
                addr_q <= addr_q + STEP;
                if (strided_q) begin
                    run_left_q <= run_left_q - SW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ilv_ctrl_fsm.sv
module ilv_ctrl_fsm
    import ilv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cfg_bad_i,
    input  logic total_zero_i,
    input  logic beat_i,
    input  logic last_i,
    output logic load_o,
    output logic valid_o,
    output logic done_o,
    output logic err_o
);
    ilv_state_e state_q;
    ilv_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (cfg_bad_i) begin
                        state_d = ST_FAULT;
                    end else if (total_zero_i) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_EMIT;
                    end
                end
            end
            ST_EMIT: begin
                if (beat_i && last_i) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o  = (state_q == ST_IDLE) && start_i && !cfg_bad_i && !total_zero_i;
        valid_o = (state_q == ST_EMIT);
        done_o  = (state_q == ST_DONE);
        err_o   = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
    import ilv_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 16,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [TW-1:0] total_qw_i,
    input  logic [SW-1:0] run_qw_i,
    input  logic [SW-1:0] skip_qw_i,
    output logic [AW-1:0] addr_o,
    output logic          addr_valid_o,
    input  logic          addr_ready_i,
    output logic          done_o,
    output logic          cfg_err_o
);
    logic cfg_bad;
    logic total_zero;
    logic strided;
    logic load;
    logic beat;
    logic last;
    logic valid;

    assign beat         = valid && addr_ready_i;
    assign addr_valid_o = valid;

    ilv_cfg_check #(.TW(TW), .SW(SW)) u_cfg (
        .mode_i       (mode_i),
        .total_qw_i   (total_qw_i),
        .run_qw_i     (run_qw_i),
        .cfg_bad_o    (cfg_bad),
        .total_zero_o (total_zero),
        .strided_o    (strided)
    );

    ilv_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cfg_bad_i    (cfg_bad),
        .total_zero_i (total_zero),
        .beat_i       (beat),
        .last_i       (last),
        .load_o       (load),
        .valid_o      (valid),
        .done_o       (done_o),
        .err_o        (cfg_err_o)
    );

    ilv_stride_cnt #(.AW(AW), .TW(TW), .SW(SW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .beat_i    (beat),
        .strided_i (strided),
        .base_i    (base_addr_i),
        .total_i   (total_qw_i),
        .run_i     (run_qw_i),
        .skip_i    (skip_qw_i),
        .addr_o    (addr_o),
        .last_o    (last)
    );
endmodule

// File: rtl/ilv_addr_gen_chk.sv
module ilv_addr_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [AW-1:0] addr_o,
    input logic          addr_valid_o,
    input logic          addr_ready_i,
    input logic          done_o,
    input logic          cfg_err_o
);
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o && !addr_ready_i |=> addr_valid_o && $stable(addr_o)); // R7

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> addr_o[3:0] == 4'h0); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !addr_valid_o); // R4

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> !cfg_err_o && !addr_valid_o && !done_o); // R6

    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_valid_o, done_o, cfg_err_o})); // R6

    AST_VALID_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid_o) |-> $past(start_i)); // R2

    AST_STALL_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o && !addr_ready_i |=> !done_o && !cfg_err_o); // R9

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(addr_valid_o && addr_ready_i) || $past(start_i)); // R5
endmodule

bind ilv_addr_gen ilv_addr_gen_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .addr_o       (addr_o),
    .addr_valid_o (addr_valid_o),
    .addr_ready_i (addr_ready_i),
    .done_o       (done_o),
    .cfg_err_o    (cfg_err_o)
);

// File: tb/ilv_addr_gen_bench.sv
module ilv_addr_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int TW = 16;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic [AW-1:0] base_addr_i = '0;
    logic [TW-1:0] total_qw_i = '0;
    logic [SW-1:0] run_qw_i = '0;
    logic [SW-1:0] skip_qw_i = '0;
    logic [AW-1:0] addr_o;
    logic          addr_valid_o;
    logic          addr_ready_i = 1'b0;
    logic          done_o;
    logic          cfg_err_o;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ilv_addr_gen #(.AW(AW), .TW(TW), .SW(SW)) u_ilv_addr_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .base_addr_i  (base_addr_i),
        .total_qw_i   (total_qw_i),
        .run_qw_i     (run_qw_i),
        .skip_qw_i    (skip_qw_i),
        .addr_o       (addr_o),
        .addr_valid_o (addr_valid_o),
        .addr_ready_i (addr_ready_i),
        .done_o       (done_o),
        .cfg_err_o    (cfg_err_o)
    );

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input int idx,
                                                input int runq, input int skipq, input bit strided);
        logic [AW-1:0] aligned;
        int grp;
        aligned = base & ~AW'(15);
        grp = strided ? idx / runq : 0;
        return aligned + AW'(16 * (idx + grp * skipq));
    endfunction

    task automatic run_case(input logic [1:0] mode, input logic [AW-1:0] base, input int total,
                            input int runq, input int skipq, input bit stall, input bit disturb);
        bit bad;
        bit strided;
        int idx;
        int guard;
        string tag;
        bad = (mode == 2'd1) || (mode == 2'd3) || (mode == 2'd2 && runq == 0);
        strided = (mode == 2'd2);
        tag = strided ? "R3" : "R2";
        @(negedge clk);
        mode_i = mode;
        base_addr_i = base;
        total_qw_i = TW'(total);
        run_qw_i = SW'(runq);
        skip_qw_i = SW'(skipq);
        addr_ready_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (bad) begin
            // R6: error pulse, nothing else
            check(cfg_err_o && !addr_valid_o && !done_o, "R6", AW'({cfg_err_o, addr_valid_o, done_o}), AW'(3'b100));
            @(negedge clk);
            check(!cfg_err_o && !addr_valid_o && !done_o, "R6", AW'({cfg_err_o, addr_valid_o, done_o}), AW'(0));
            return;
        end
        if (total == 0) begin
            // R5: immediate done
            check(done_o && !addr_valid_o, "R5", AW'({done_o, addr_valid_o}), AW'(2'b10));
            @(negedge clk);
            check(!done_o && !addr_valid_o, "R5", AW'({done_o, addr_valid_o}), AW'(0));
            return;
        end
        idx = 0;
        guard = 0;
        while (idx < total && guard < 4000) begin
            logic [AW-1:0] e;
            e = exp_addr(base, idx, runq, skipq, strided);
            check(addr_valid_o === 1'b1 && addr_o === e,
                  (guard > idx) ? "R7" : ((base[3:0] != 0) ? "R8" : (disturb ? "R9" : tag)), addr_o, e);
            if (disturb) begin
                start_i = 1'b1;
                base_addr_i = ~base;
                run_qw_i = run_qw_i + SW'(3);
                skip_qw_i = skip_qw_i + SW'(5);
                mode_i = 2'd1;
                total_qw_i = TW'(1);
            end
            addr_ready_i = stall ? lfsr[0] : 1'b1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (addr_ready_i) idx++;
            guard++;
            @(negedge clk);
        end
        start_i = 1'b0;
        addr_ready_i = 1'b0;
        // R4: done one cycle after final handshake
        check(done_o && !addr_valid_o, "R4", AW'({done_o, addr_valid_o}), AW'(2'b10));
        @(negedge clk);
        check(!done_o && !addr_valid_o, "R4", AW'({done_o, addr_valid_o}), AW'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet during and after reset
        check(!addr_valid_o && !done_o && !cfg_err_o, "R1", AW'({addr_valid_o, done_o, cfg_err_o}), AW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!addr_valid_o && !done_o && !cfg_err_o, "R1", AW'({addr_valid_o, done_o, cfg_err_o}), AW'(0));

        // R2: linear sweep
        for (int t = 0; t <= 20; t++) begin
            run_case(2'd0, 32'h0000_4000, t, 0, 0, 1'b0, 1'b0);
        end
        // R3: strided sweep over run, skip and total
        for (int r = 1; r <= 4; r++) begin
            for (int s = 0; s <= 3; s++) begin
                for (int t = 0; t <= 10; t++) begin
                    run_case(2'd2, 32'h0001_0000, t, r, s, 1'b0, 1'b0);
                end
            end
        end
        // R7: stalls with both modes
        run_case(2'd0, 32'h0000_8000, 17, 0, 0, 1'b1, 1'b0);
        for (int r = 1; r <= 3; r++) begin
            run_case(2'd2, 32'h0002_0000, 13, r, 2, 1'b1, 1'b0);
        end
        // R8: misaligned bases and wrap at top of address space
        run_case(2'd0, 32'h0000_300F, 5, 0, 0, 1'b0, 1'b0);
        run_case(2'd2, 32'h0000_5007, 9, 2, 3, 1'b1, 1'b0);
        run_case(2'd2, 32'hFFFF_FFC9, 6, 2, 1, 1'b0, 1'b0);
        // R9: start and config changes mid-transfer have no effect
        run_case(2'd2, 32'h0003_0000, 11, 3, 1, 1'b1, 1'b1);
        run_case(2'd0, 32'h0003_8000, 7, 0, 0, 1'b0, 1'b1);
        // R6: rejected configurations
        run_case(2'd1, 32'h0000_1000, 5, 2, 1, 1'b0, 1'b0);
        run_case(2'd3, 32'h0000_1000, 5, 2, 1, 1'b0, 1'b0);
        run_case(2'd2, 32'h0000_1000, 5, 0, 1, 1'b0, 1'b0);
        run_case(2'd2, 32'h0000_1000, 0, 0, 1, 1'b0, 1'b0);
        // recovery after an error
        run_case(2'd2, 32'h0000_2000, 4, 1, 1, 1'b0, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule